// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block sends audio samples to a voice codec over a three-wire serial link. The codec owns the timing: it supplies the bit clock and an active-high frame sync. Both are brought into the system clock domain and only their rising bit-clock edges are acted on. The CPU side writes one 16-bit word at a time into a holding register. At the first bit of each word slot, the block moves that word into a shift register and sends it MSB first. Each frame carries two such words after a one-bit delay.

The control flow is a five-state machine:
- OFF: the transmitter is held in reset because `xmit_en` is low. Any state moves to OFF when `xmit_en` falls.
- ARM: the block is enabled and waits for the first frame sync. It leaves to DELAY on a frame sync.
- DELAY: the one-bit gap after a frame sync. It moves to SHIFT on the next bit clock, or stays in DELAY if another sync arrives.
- SHIFT: the 32 data bits are sent here. It goes to GAP after the last bit, or back to DELAY on any frame sync.
- GAP: the line idles after a complete frame. It moves to DELAY on the next frame sync.

A ready flag, and an interrupt pulse tied to it, pace the CPU one word at a time. Two sticky flags report trouble. One is a frame sync that arrived before the frame was complete. The other is a word slot that found the holding register empty.

Top module: `frame_serial_tx`

## Requirements
- R1: After reset, `sdata`, `ready`, `irq`, `sync_err` and `underflow` are all 0.
- R2: A frame sync seen high at a bit-clock rising edge starts a frame. The first data bit is driven at the next rising edge (a one-bit delay). After that come 32 bits: two 16-bit words, MSB first, one bit per rising edge, each stable through the following falling edge.
- R3: `sdata` is 0 in the delay slot, after the 32nd bit until the next frame sync, and whenever no frame is in progress.
- R4: While `xmit_en` is 0, the block stays in reset: `ready` is 0 and `sdata` is 0. After `xmit_en` rises, nothing is sent until the next frame sync.
- R5: `ready` is 1 exactly when the block is enabled and the holding register is empty. A write sets the register full, so `ready` is 0 in the following cycle.
- R6: Each word moves from the holding register to the shift register at the rising edge that drives its MSB. This frees the holding register.
- R7: `irq` is a single-cycle pulse. It fires one cycle after `ready` rises, and also at each word slot that finds the holding register empty.
- R8: A frame sync in the delay slot, or before all 32 bits are out, restarts the frame. The partly sent word is dropped, and the restarted frame takes its first word from the holding register.
- R9: `sync_err` is set by the condition in R8 and stays set through later good frames. It is cleared only by `flag_clr` or reset. A set event in the same cycle wins over the clear.
- R10: A word slot that finds the holding register empty sends the previous word again and sets the sticky `underflow` flag. `underflow` is cleared by `flag_clr`.
- R11: A frame sync at the edge directly after the 32nd data bit (a 33-bit frame period) starts a new frame without setting `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| xmit_en | input | 1 | Transmitter enable; 0 holds the transmitter in reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Word to send |
| flag_clr | input | 1 | Clears both sticky flags |
| bclk | input | 1 | Bit clock from the external master |
| fsync | input | 1 | Active-high frame sync from the external master |
| sdata | output | 1 | Serial data, MSB first |
| ready | output | 1 | Holding register can take a word |
| irq | output | 1 | Transmit interrupt pulse |
| sync_err | output | 1 | Sticky early-frame-sync flag |
| underflow | output | 1 | Sticky empty-slot flag |

## Verification
A bit-clock rising edge passes through two synchronizer flops and an edge detector, so the new `sdata` value is registered on the third clk edge after it. The bench holds each bit-clock phase for eight clk cycles and reads `sdata` at the falling edge, which leaves a margin of several cycles. `ready` is checked one cycle after a write. `irq` is checked in the cycle after each pulse to confirm that it has dropped. The sticky flags are read a whole frame after the event that sets them and again one cycle after `flag_clr`. Every bit position of every frame is compared: against the scoreboard queue for data bits, and against 0 for the delay slot, the gaps and the disabled periods.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [2:0] {
        TXS_OFF,
        TXS_ARM,
        TXS_DELAY,
        TXS_SHIFT,
        TXS_GAP
    } txs_state_t;
endpackage

// File: rtl/txs_line_sync.sv
module txs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic bit_tick,
    output logic fs_at_tick
);
    logic [STAGES-1:0] bclk_sr;
    logic [STAGES-1:0] fs_sr;
    logic              bclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sr   <= '0;
            fs_sr     <= '0;
            bclk_prev <= 1'b0;
        end else begin
            bclk_sr   <= {bclk_sr[STAGES-2:0], bclk};
            fs_sr     <= {fs_sr[STAGES-2:0], fsync};
            bclk_prev <= bclk_sr[STAGES-1];
        end
    end

    assign bit_tick   = bclk_sr[STAGES-1] & ~bclk_prev;
    assign fs_at_tick = fs_sr[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("txs_line_sync needs two or more stages");
    end
endmodule

// File: rtl/txs_holding.sv
module txs_holding #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            data <= wr_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // a write always leaves a word waiting
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx
    import txs_pkg::*;
#(
    parameter int WORD_W          = 16,
    parameter int WORDS_PER_FRAME = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmit_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              bclk,
    input  logic              fsync,
    output logic              sdata,
    output logic              ready,
    output logic              irq,
    output logic              sync_err,
    output logic              underflow
);
    localparam int FRAME_BITS = WORD_W * WORDS_PER_FRAME;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_BITS);

    txs_state_t        state, state_nxt;
    logic              bit_tick, fs_at_tick;
    logic              hold_full, take;
    logic [WORD_W-1:0] hold_data, new_word, shreg, last_word;
    logic [CNT_W-1:0]  cnt;
    logic              frame_done, word_edge, load_now, mid_sync, ready_d;

    txs_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fsync     (fsync),
        .bit_tick  (bit_tick),
        .fs_at_tick(fs_at_tick)
    );

    txs_holding #(.W(WORD_W)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .full   (hold_full),
        .data   (hold_data)
    );

    assign frame_done = (cnt == CNT_END);
    assign word_edge  = ((32'(cnt) % WORD_W) == 0);
    assign load_now   = xmit_en & bit_tick & ~fs_at_tick &
                        ((state == TXS_DELAY) |
                         ((state == TXS_SHIFT) & ~frame_done & word_edge));
    assign mid_sync   = xmit_en & bit_tick & fs_at_tick &
                        ((state == TXS_DELAY) | ((state == TXS_SHIFT) & ~frame_done));
    assign take       = load_now & hold_full;
    assign new_word   = hold_full ? hold_data : last_word;
    assign ready      = xmit_en & (state != TXS_OFF) & ~hold_full;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TXS_OFF;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (!xmit_en) begin
            state_nxt = TXS_OFF;
        end else begin
            unique case (state)
                TXS_OFF:   state_nxt = TXS_ARM;
                TXS_ARM,
                TXS_GAP:   if (bit_tick && fs_at_tick) state_nxt = TXS_DELAY;
                TXS_DELAY: if (bit_tick) state_nxt = fs_at_tick ? TXS_DELAY : TXS_SHIFT;
                TXS_SHIFT: if (bit_tick) begin
                               if (fs_at_tick)      state_nxt = TXS_DELAY;
                               else if (frame_done) state_nxt = TXS_GAP;
                           end
                default:   state_nxt = TXS_OFF;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata     <= 1'b0;
            shreg     <= '0;
            last_word <= '0;
            cnt       <= '0;
            ready_d   <= 1'b0;
            irq       <= 1'b0;
            sync_err  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            ready_d <= ready;
            irq     <= (ready & ~ready_d) | (load_now & ~hold_full);
            if (mid_sync)      sync_err <= 1'b1;
            else if (flag_clr) sync_err <= 1'b0;
            if (load_now && !hold_full) underflow <= 1'b1;
            else if (flag_clr)          underflow <= 1'b0;
            if (!xmit_en) begin
                sdata <= 1'b0;
                cnt   <= '0;
            end else if (bit_tick) begin
                if (load_now) begin
                    sdata     <= new_word[WORD_W-1];
                    shreg     <= new_word << 1;
                    last_word <= new_word;
                    cnt       <= cnt + CNT_W'(1);
                end else if (state == TXS_SHIFT && !fs_at_tick && !frame_done) begin
                    sdata <= shreg[WORD_W-1];
                    shreg <= shreg << 1;
                    cnt   <= cnt + CNT_W'(1);
                end else begin
                    sdata <= 1'b0;
                    if (fs_at_tick) cnt <= '0;
                end
            end
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_END);
    p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXS_ARM || state == TXS_GAP || state == TXS_DELAY) |-> !sdata);
    p_held_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_en |=> !sdata);
    p_arm_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXS_SHIFT) |-> ($past(state) == TXS_DELAY || $past(state) == TXS_SHIFT));
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !flag_clr) |=> sync_err);
    p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flag_clr) |=> underflow);
endmodule

// File: tb/test_frame_serial_tx.sv
module test_frame_serial_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BCLK  = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xmit_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata, ready, irq, sync_err, underflow;

    int checks = 0;
    int failures = 0;
    int frame_no = 0;
    int frame_len = 40;
    int inject_pos = 0;
    int skip_n = 0;
    int aborted = 0;
    bit drv_on = 1'b0;
    bit gen_on = 1'b0;
    int word_n = 0;
    logic [15:0] last_w = '0;
    logic [15:0] exp_q[$];

    int          mon_active = 0;
    int          mon_pos = 0;
    logic [15:0] mon_acc = '0;

    frame_serial_tx i_frame_serial_tx (
        .clk(clk), .rst_n(rst_n), .xmit_en(xmit_en), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .bclk(bclk), .fsync(fsync),
        .sdata(sdata), .ready(ready), .irq(irq), .sync_err(sync_err),
        .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // monitor: one call per bit slot, sampled at the falling bit-clock edge
    task automatic monitor_bit(input logic fs, input logic en_r, input logic b);
        logic [15:0] e;
        if (!en_r) begin
            mon_active = 0;
            check(b == 1'b0, "R4 line quiet while disabled", b, 0);
        end else if (fs) begin
            if (mon_active != 0 && mon_pos > 0 && mon_pos < 32 && (mon_pos % 16) != 0) begin
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                aborted++;
            end
            mon_active = 1;
            mon_pos = 0;
            check(b == 1'b0, "R2 delay slot after frame sync", b, 0);
        end else if (mon_active != 0 && mon_pos < 32) begin
            mon_pos++;
            mon_acc = {mon_acc[14:0], b};
            if ((mon_pos % 16) == 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 word sent with none expected", mon_acc, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(mon_acc == e, "R2 R6 R10 word content", mon_acc, e);
                end
            end
        end else begin
            check(b == 1'b0, "R3 line idle outside frame", b, 0);
        end
    endtask

    // bit clock, frame sync and monitor
    initial begin
        int pos = 0;
        int cur_inj = 0;
        int flen = 40;
        logic en_r;
        logic fs_r;
        wait (gen_on);
        forever begin
            if (pos == 0) begin
                cur_inj = inject_pos;
                inject_pos = 0;
                flen = frame_len;
                fsync = 1'b1;
            end else if (cur_inj != 0 && pos == cur_inj) begin
                fsync = 1'b1;
                pos = 0;
                cur_inj = 0;
            end else begin
                fsync = 1'b0;
            end
            repeat (HALF_BCLK) @(negedge clk);
            bclk = 1'b1;
            en_r = xmit_en;
            fs_r = fsync;
            repeat (HALF_BCLK) @(negedge clk);
            monitor_bit(fs_r, en_r, sdata);
            bclk = 1'b0;
            pos++;
            if (pos >= flen) begin
                pos = 0;
                frame_no++;
            end
        end
    end

    // driver: answers each interrupt with a word, pushing what must appear
    initial begin
        forever begin
            @(negedge clk);
            if (drv_on && irq) begin
                if (skip_n > 0) begin
                    skip_n--;
                    exp_q.push_back(last_w);
                    @(negedge clk);
                    check(irq == 1'b0, "R7 irq single cycle", irq, 0);
                end else begin
                    word_n++;
                    last_w = 16'h3A71 + 16'(word_n * 16'h1F35);
                    wr_data = last_w;
                    wr_en = 1'b1;
                    exp_q.push_back(last_w);
                    @(negedge clk);
                    wr_en = 1'b0;
                    check(ready == 1'b0, "R5 ready low after write", ready, 0);
                    check(irq == 1'b0, "R7 irq single cycle", irq, 0);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic wait_frames(input int n);
        int target;
        target = frame_no + n;
        wait (frame_no >= target);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(sdata == 0, "R1 sdata in reset", sdata, 0);
        check(ready == 0, "R1 ready in reset", ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(sync_err == 0, "R1 sync_err after reset", sync_err, 0);
        check(underflow == 0, "R1 underflow after reset", underflow, 0);

        gen_on = 1'b1;
        wait_frames(2);

        // R4: preload while disabled, ready stays low
        @(negedge clk);
        last_w = 16'hA5C3;
        wr_data = last_w;
        wr_en = 1'b1;
        exp_q.push_back(last_w);
        @(negedge clk);
        wr_en = 1'b0;
        check(ready == 0, "R4 ready low while disabled", ready, 0);

        // enable mid-frame; data must wait for the next frame sync
        repeat (100) @(negedge clk);
        @(negedge bclk);
        @(negedge clk);
        xmit_en = 1'b1;
        drv_on = 1'b1;
        repeat (3) @(negedge clk);
        check(ready == 0, "R5 ready low with word waiting", ready, 0);

        wait_frames(5);
        check(sync_err == 0, "R9 no error on regular frames", sync_err, 0);
        check(underflow == 0, "R10 no underflow when fed", underflow, 0);

        // R11: tight 33-bit frame period
        frame_len = 33;
        wait_frames(4);
        frame_len = 40;
        wait_frames(2);
        check(sync_err == 0, "R11 sync right after last bit is good", sync_err, 0);

        // R8/R9: early frame sync
        inject_pos = 10;
        wait_frames(3);
        check(sync_err == 1, "R9 early sync sets flag", sync_err, 1);
        check(aborted == 1, "R8 one partial word dropped", aborted, 1);
        wait_frames(2);
        check(sync_err == 1, "R9 flag sticky through good frames", sync_err, 1);
        pulse_clr();
        check(sync_err == 0, "R9 flag cleared by flag_clr", sync_err, 0);

        // R10: starve one slot
        skip_n = 1;
        wait_frames(3);
        check(underflow == 1, "R10 underflow flag set", underflow, 1);
        check(sync_err == 0, "R9 stays clear after clear", sync_err, 0);
        pulse_clr();
        check(underflow == 0, "R10 underflow cleared", underflow, 0);
        wait_frames(2);

        // R4: disable again
        drv_on = 1'b0;
        @(negedge bclk);
        @(negedge clk);
        xmit_en = 1'b0;
        repeat (3) @(negedge clk);
        check(ready == 0, "R4 ready low after disable", ready, 0);
        check(sdata == 0, "R4 sdata low after disable", sdata, 0);
        wait_frames(1);
        finish_run();
    end
endmodule